// File: doc/BRIEF.md
# Protected System Clock Control Register

This block holds one 8-bit system clock control register that sits on a simple byte-wide bus with a write strobe and a readback port. It turns the stored bits into the clock-related control signals the rest of the chip uses. These signals select the clock output pin function, disable the main oscillator, gate the peripheral clock during wait mode, choose the sub-oscillator drive strength, connect the sub-oscillator pins, and pick the watchdog action.

Writes pass through several layers of protection. A protect-enable input must be high for any write to take effect. A clock-change lock input freezes the two bits that stop clocks. The watchdog action bit can be set by software but never cleared by it. When stop mode is entered, hardware forces the sub-oscillator drive bit high.

The divided peripheral clocks for the output pin come from a free-running counter inside the block. This counter runs on the block clock, which also serves as the peripheral clock.

Top module: `clk_ctrl_reg`

## Requirements
- R1: After reset the register reads 8'h08: only bit 3 (sub-oscillator high drive) is set, and the divider counter is cleared.
- R2: A write strobe while `prot_en` is 0 leaves every register bit unchanged.
- R3: While `clk_lock` is 1, a write keeps bit 2 (wait-mode peripheral stop) and bit 5 (main oscillator disable) unchanged, and it still updates bits 1:0, 3 and 4.
- R4: Bit 6 (watchdog action, 0 = interrupt, 1 = reset) can be set by a write. Once it is 1, no write can clear it; only reset does.
- R5: A `stop_enter` pulse sets bit 3 to 1, and this takes priority over a write of 0 to bit 3 in the same cycle.
- R6: Bits 1:0 drive `clkout_pin` as follows: 00 gives `port_dout`, 01 gives `lsclk_in`, 10 gives the peripheral clock divided by 8, and 11 gives the peripheral clock divided by 32.
- R7: When bit 5 is 1, `main_osc_dis` is 1 and `main_osc_out` is held high. When bit 5 is 0, `main_osc_out` follows `main_osc_in`.
- R8: Bit 7 is stored and read as 0, whatever value is written to it.
- R9: `periph_clk_en` is 0 exactly when `wait_mode` is 1 and bit 2 is 1. The low-speed clock on `clkout_pin` is never gated.
- R10: The divide-by-8 output is bit 2, and the divide-by-32 output is bit 4, of a 5-bit counter that counts up once per clock from 0 after reset.
- R11: `rd_data` shows the register contents in the cycle after the updating edge, with no extra delay. Bit 4 drives `xc_sel`, bit 3 drives `sub_drive_hi`, and bit 6 drives `wdt_reset_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral/system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Register readback |
| prot_en | input | 1 | Global write enable |
| clk_lock | input | 1 | Freezes the clock-stop bits |
| stop_enter | input | 1 | Stop-mode entry pulse |
| wait_mode | input | 1 | Device is in wait mode |
| lsclk_in | input | 1 | Low-speed clock |
| port_dout | input | 1 | Port data for the output pin |
| main_osc_in | input | 1 | Main oscillator clock |
| clkout_pin | output | 1 | Clock output pin |
| main_osc_dis | output | 1 | Main oscillator disable |
| main_osc_out | output | 1 | Main oscillator clock after the disable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| sub_drive_hi | output | 1 | Sub-oscillator high drive |
| xc_sel | output | 1 | Sub-oscillator pin connect |
| wdt_reset_sel | output | 1 | Watchdog action is reset |

## Verification
Any wrong stored bit appears on `rd_data` on the first falling edge after the update. It also shows on the decoded control output, so a corrupted protection layer is seen within one cycle of the write that should have been blocked. A counter that is off by a phase, or a swapped mux code, shows on `clkout_pin` within one divide period, at most 32 cycles. For that reason the bench tracks the counter from reset and compares the pin every cycle.

// File: rtl/clk_ctrl_reg.sv
module clk_ctrl_reg #(
  parameter int DW = 8,
  parameter int CNT_W = 5,
  parameter logic [DW-1:0] RST_VAL = 8'h08
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  input  logic          prot_en,
  input  logic          clk_lock,
  input  logic          stop_enter,
  input  logic          wait_mode,
  input  logic          lsclk_in,
  input  logic          port_dout,
  input  logic          main_osc_in,
  output logic          clkout_pin,
  output logic          main_osc_dis,
  output logic          main_osc_out,
  output logic          periph_clk_en,
  output logic          sub_drive_hi,
  output logic          xc_sel,
  output logic          wdt_reset_sel
);
  localparam int B_WSTOP = 2;
  localparam int B_DRV   = 3;
  localparam int B_XC    = 4;
  localparam int B_MOFF  = 5;
  localparam int B_WDT   = 6;
  localparam int B_RSV   = 7;

  logic [DW-1:0]    ctl_q, ctl_d;
  logic [CNT_W-1:0] div_q;
  logic             do_wr;

  assign do_wr = wr_en & prot_en;

  always_comb begin
    ctl_d = ctl_q;
    if (do_wr) begin
      ctl_d[1:0]   = wr_data[1:0];
      ctl_d[B_DRV] = wr_data[B_DRV];
      ctl_d[B_XC]  = wr_data[B_XC];
      ctl_d[B_WDT] = ctl_q[B_WDT] | wr_data[B_WDT];
      if (!clk_lock) begin
        ctl_d[B_WSTOP] = wr_data[B_WSTOP];
        ctl_d[B_MOFF]  = wr_data[B_MOFF];
      end
    end
    if (stop_enter) ctl_d[B_DRV] = 1'b1;
    ctl_d[B_RSV] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ctl_q <= RST_VAL;
    else        ctl_q <= ctl_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + 1'b1;

  always_comb begin
    case (ctl_q[1:0])
      2'b00:   clkout_pin = port_dout;
      2'b01:   clkout_pin = lsclk_in;
      2'b10:   clkout_pin = div_q[2];
      default: clkout_pin = div_q[CNT_W-1];
    endcase
  end

  assign rd_data       = ctl_q;
  assign main_osc_dis  = ctl_q[B_MOFF];
  assign main_osc_out  = ctl_q[B_MOFF] | main_osc_in;
  assign periph_clk_en = ~(wait_mode & ctl_q[B_WSTOP]);
  assign sub_drive_hi  = ctl_q[B_DRV];
  assign xc_sel        = ctl_q[B_XC];
  assign wdt_reset_sel = ctl_q[B_WDT];

  AST_NO_PROT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!prot_en && !stop_enter) |=> $stable(rd_data)); // R2
  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && clk_lock) |=> (rd_data[B_WSTOP] == $past(rd_data[B_WSTOP]) &&
                             rd_data[B_MOFF] == $past(rd_data[B_MOFF]))); // R3
  AST_WDT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_reset_sel |=> wdt_reset_sel); // R4
  AST_STOP_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_enter |=> sub_drive_hi); // R5
  AST_OSC_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    main_osc_dis |-> main_osc_out); // R7
  AST_WAIT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_mode && rd_data[B_WSTOP]) |-> !periph_clk_en); // R9
endmodule

// File: tb/tb_clk_ctrl_reg.sv
module tb_clk_ctrl_reg;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, prot_en = 0, clk_lock = 0, stop_enter = 0, wait_mode = 0;
  logic lsclk_in = 0, port_dout = 0, main_osc_in = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic clkout_pin, main_osc_dis, main_osc_out, periph_clk_en;
  logic sub_drive_hi, xc_sel, wdt_reset_sel;

  int n_tests = 0, n_fail = 0;
  logic [7:0] m;
  logic [4:0] cnt;
  bit done = 0;

  clk_ctrl_reg dut (.*);

  always #10 clk = ~clk;

  function automatic logic [7:0] nxt(logic [7:0] r, logic we, logic pe, logic lk,
                                     logic st, logic [7:0] d);
    logic [7:0] n = r;
    if (we && pe) begin
      n[1:0] = d[1:0]; n[3] = d[3]; n[4] = d[4]; n[6] = r[6] | d[6];
      if (!lk) begin n[2] = d[2]; n[5] = d[5]; end
    end
    if (st) n[3] = 1'b1;
    n[7] = 1'b0;
    return n;
  endfunction

  function automatic logic exp_pin(logic [7:0] r, logic [4:0] c, logic ls, logic pd);
    case (r[1:0])
      2'b00: return pd;
      2'b01: return ls;
      2'b10: return c[2];
      default: return c[4];
    endcase
  endfunction

  task automatic chk(logic ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    logic [6:0] ea, aa;
    chk(rd_data == m, tag, rd_data, m);
    ea = {exp_pin(m, cnt, lsclk_in, port_dout), m[5], m[5] | main_osc_in,
          ~(wait_mode & m[2]), m[3], m[4], m[6]};
    aa = {clkout_pin, main_osc_dis, main_osc_out, periph_clk_en,
          sub_drive_hi, xc_sel, wdt_reset_sel};
    chk(aa == ea, tag, aa, ea);
  endtask

  task automatic step(logic we, logic pe, logic lk, logic st, logic [7:0] d, string tag);
    wr_en = we; prot_en = pe; clk_lock = lk; stop_enter = st; wr_data = d;
    @(posedge clk);
    m = nxt(m, we, pe, lk, st, d);
    cnt = cnt + 1;
    @(negedge clk);
    wr_en = 0; stop_enter = 0;
    check_all(tag);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m = 8'h08; cnt = 0;
    repeat (3) @(negedge clk);
    check_all("R1 reset");
    rst_n = 1;
    check_all("R1 after release");
    port_dout = 1;
    step(0, 0, 0, 0, 8'h00, "R6 port select");
    step(1, 0, 0, 0, 8'h7F, "R2 write blocked");
    chk(rd_data == 8'h08, "R2", rd_data, 8'h08);
    step(1, 1, 0, 0, 8'h24, "R3 set stop bits");
    step(1, 1, 1, 0, 8'h1B, "R3 locked write");
    chk(rd_data == 8'h3F, "R3", rd_data, 8'h3F);
    step(1, 1, 0, 0, 8'hC0, "R4 set wdt bit");
    step(1, 1, 0, 0, 8'h00, "R4 clear attempt");
    chk(wdt_reset_sel == 1, "R4", wdt_reset_sel, 1);
    step(1, 1, 0, 1, 8'h00, "R5 stop over write");
    chk(sub_drive_hi == 1, "R5", sub_drive_hi, 1);
    step(1, 1, 0, 0, 8'hFF, "R8 reserved bit");
    chk(rd_data[7] == 0, "R8", rd_data[7], 0);
    main_osc_in = 0; #1;
    chk(main_osc_out == 1, "R7 osc held high", main_osc_out, 1);
    wait_mode = 1; #1;
    chk(periph_clk_en == 0, "R9 gated in wait", periph_clk_en, 0);
    step(1, 1, 0, 0, 8'h05, "R9 low-speed pin");
    lsclk_in = 1; #1;
    chk(clkout_pin == 1, "R9 lsclk not gated", clkout_pin, 1);
    wait_mode = 0;
    step(1, 1, 0, 0, 8'h02, "R10 div8");
    for (int i = 0; i < 34; i++) step(0, 1, 0, 0, 8'h00, "R10 div8 run");
    step(1, 1, 0, 0, 8'h03, "R10 div32");
    for (int i = 0; i < 66; i++) step(0, 1, 0, 0, 8'h00, "R10 div32 run");
    for (int i = 0; i < 400; i++) begin
      wait_mode   = 1'($urandom);
      lsclk_in    = 1'($urandom);
      port_dout   = 1'($urandom);
      main_osc_in = 1'($urandom);
      step(1'($urandom), 1'($urandom), 1'($urandom), ($urandom % 8) == 0,
           8'($urandom), "R11 random");
    end
    rst_n = 0; m = 8'h08; cnt = 0; #1;
    check_all("R1 second reset");
    @(negedge clk); rst_n = 1;
    step(0, 1, 0, 0, 8'h00, "R4 cleared by reset");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule